// File: doc/BRIEF.md
# Disciplined UTC Time-of-Day Engine

This block keeps time for a network switch. A free-running cycle counter, 64 bits wide, advances on every clock. Software reads it one 32-bit word at a time through a single word-select input. Beside the counter, a time-of-day pair (whole seconds plus a sub-second count) advances by a nominal 6.4 ns per clock. The sub-second count is kept in fixed point, so the fractional step does not drift.

Software never sets the time directly. It first arms a seconds value with a command. It then programs a virtual pulse pin with a raw cycle-count deadline. When the cycle counter reaches that deadline, the block emits a one-cycle pulse. On that pulse it loads the armed seconds and zeroes the sub-second count. A second command stores a signed trim, in sub-second units. The trim is added to the sub-second remainder each time a second rolls over, which lets software steer the rate of the clock.

Top module: `utc_timekeeper`

## Requirements
- R1: The cycle counter leaves reset at the value FRC_RST and then grows by exactly one per clock. With `rd_hi`=1 the read word is bits 63:32; with `rd_hi`=0 it is bits 31:0.
- R2: A read of high word, then low word, then high word on successive cycles may show two different high words. In that case a fresh low-word read gives a value that belongs to the second high word, which is the first high word plus one.
- R3: A pin write takes effect only when the pin index is 7 and the mode code is 2. Any other write leaves the pin as it was. An accepted write with the enable bit at 0 leaves the pin unarmed, so no pulse follows.
- R4: An armed pin raises `pps_pulse` for one cycle. This happens on the first clock at which the counter is at or above the target, so the counter read during the pulse is target+1. After that the pin disarms and does not fire again until it is reprogrammed.
- R5: Command code 0 arms its seconds value. On the next pulse, `utc_sec` takes that value and `utc_subsec` becomes 0. The arm is then used up, so a later pulse with no new arm changes nothing.
- R6: Command code 3 stores its 32-bit signed value as the trim. Every other command code (1, 2, 4 to 15) arms nothing and leaves the trim unchanged.
- R7: On each clock the sub-second accumulator grows by STEP_FX/2^FRAC_W units. When the accumulator would reach SEC_UNITS, `utc_sec` goes up by one. The accumulator then keeps the excess plus the trim.
- R8: After the trim is added, the remainder is held inside [0, SEC_UNITS). A large negative trim gives 0. A large positive trim gives just under one second.
- R9: A pin programmed with a target that the counter has already passed fires on the clock right after the write is accepted.
- R10: While reset is held, `pps_pulse` is 0, `utc_sec` is 0 and `utc_subsec` is 0. Reset also clears the pin enable, the arm flag and the trim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_wr | input | 1 | Pin configuration write strobe |
| pin_idx | input | 8 | Pin index (7 selects the virtual pin) |
| pin_mode | input | 4 | Pin mode code (2 means virtual pin) |
| pin_en | input | 1 | Enable bit written with the pin |
| pin_target | input | FRC_W | Cycle count at which the pin fires |
| cmd_wr | input | 1 | Time command write strobe |
| cmd_op | input | 4 | Command code: 0 arm seconds, 3 set trim |
| cmd_adj | input | 32 | Signed trim in sub-second units |
| cmd_sec | input | 32 | Seconds value to arm |
| rd_hi | input | 1 | Word select for counter reads (1 = high word) |
| rd_word | output | WORD_W | Selected counter word |
| pps_pulse | output | 1 | One-cycle virtual pin pulse |
| utc_sec | output | 32 | Time-of-day seconds |
| utc_subsec | output | SUB_W | Time-of-day sub-second units |

## Verification
Some properties are checked on every cycle. The counter steps by one. A pulse with no rewrite is never followed by a second pulse. Every pulse that consumes an arm loads the last armed seconds and a zero sub-second. The sub-second count stays below one second. Seconds only ever hold or advance by one, except when a load happens. Other behaviours need the bench's scenarios. These are the exact cycle on which a second rolls over, the remainder under a sweep of positive, negative and saturating trims, the rejection of wrong pin index or mode, ignored command codes, and the word-wrap read sequence near a carry into the high word.

// File: rtl/utc_pkg.sv
package utc_pkg;
  localparam int OP_W      = 4;
  localparam int PIN_IDX_W = 8;
  localparam int MODE_W    = 4;
  localparam int SEC_W     = 32;
  localparam int TRIM_W    = 32;

  localparam logic [OP_W-1:0]      OP_ARM_SEC = 4'd0;
  localparam logic [OP_W-1:0]      OP_TRIM    = 4'd3;
  localparam logic [PIN_IDX_W-1:0] VPIN_IDX   = 8'd7;
  localparam logic [MODE_W-1:0]    VPIN_MODE  = 4'h2;
endpackage

// File: rtl/utc_rst_sync.sv
module utc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/utc_frc.sv
module utc_frc #(
  parameter int               FRC_W   = 64,
  parameter int               WORD_W  = 32,
  parameter logic [FRC_W-1:0] FRC_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_hi,
  output logic [FRC_W-1:0]  frc_o,
  output logic [WORD_W-1:0] rd_word_o
);
  localparam int NWORD = FRC_W / WORD_W;

  logic [FRC_W-1:0]  cnt_q, cnt_d;
  logic              cnt_en;
  logic [WORD_W-1:0] word_a [NWORD];

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q + FRC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= FRC_RST;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < NWORD; g++) begin : g_word
    assign word_a[g] = cnt_q[g*WORD_W +: WORD_W];
  end

  assign rd_word_o = rd_hi ? word_a[NWORD-1] : word_a[0];
  assign frc_o     = cnt_q;
endmodule

// File: rtl/utc_vpin.sv
module utc_vpin
  import utc_pkg::*;
#(
  parameter int FRC_W = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pin_wr,
  input  logic [PIN_IDX_W-1:0] pin_idx,
  input  logic [MODE_W-1:0]    pin_mode,
  input  logic                 pin_en,
  input  logic [FRC_W-1:0]     pin_target,
  input  logic [FRC_W-1:0]     frc,
  output logic                 fire_o,
  output logic                 pps_o
);
  logic             en_q, en_d;
  logic [FRC_W-1:0] tgt_q, tgt_d;
  logic             pps_q;
  logic             accept;
  logic             fire;

  always_comb begin
    accept = pin_wr && (pin_idx == VPIN_IDX) && (pin_mode == VPIN_MODE);
    fire   = en_q && (frc >= tgt_q);
    tgt_d  = accept ? pin_target : tgt_q;
    if (accept)    en_d = pin_en;
    else if (fire) en_d = 1'b0;
    else           en_d = en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      tgt_q <= '0;
      pps_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      pps_q <= fire;
      if (accept) tgt_q <= tgt_d;
    end
  end

  assign fire_o = fire;
  assign pps_o  = pps_q;
endmodule

// File: rtl/utc_tod.sv
module utc_tod
  import utc_pkg::*;
#(
  parameter int unsigned SEC_UNITS = 1000000000,
  parameter int          FRAC_W    = 8,
  parameter int unsigned STEP_FX   = 1638,
  parameter int          SUB_W     = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [TRIM_W-1:0] cmd_adj,
  input  logic [SEC_W-1:0]  cmd_sec,
  input  logic              apply_load,
  output logic              armed_o,
  output logic [SEC_W-1:0]  sec_o,
  output logic [SUB_W-1:0]  subsec_o
);
  localparam logic signed [63:0] SEC_FX  = 64'(SEC_UNITS) <<< FRAC_W;
  localparam logic signed [63:0] STEP_S  = 64'(STEP_FX);
  localparam int                 ACC_W   = $clog2(SEC_UNITS) + FRAC_W + 1;

  logic [ACC_W-1:0]  acc_q, acc_d;
  logic [SEC_W-1:0]  sec_q, sec_d;
  logic [SEC_W-1:0]  arm_sec_q;
  logic              armed_q, armed_d;
  logic [TRIM_W-1:0] trim_q;
  logic              arm_we, trim_we;
  logic signed [63:0] sum_s, trim_fx, wrap_s, wrap_sat;
  logic              roll;

  always_comb begin
    arm_we  = cmd_wr && (cmd_op == OP_ARM_SEC);
    trim_we = cmd_wr && (cmd_op == OP_TRIM);

    if (arm_we)          armed_d = 1'b1;
    else if (apply_load) armed_d = 1'b0;
    else                 armed_d = armed_q;

    sum_s   = $signed({{(64-ACC_W){1'b0}}, acc_q}) + STEP_S;
    trim_fx = $signed({{(64-TRIM_W){trim_q[TRIM_W-1]}}, trim_q}) <<< FRAC_W;
    roll    = (sum_s >= SEC_FX);
    wrap_s  = sum_s - SEC_FX + trim_fx;
    if (wrap_s < 64'sd0)        wrap_sat = 64'sd0;
    else if (wrap_s >= SEC_FX)  wrap_sat = SEC_FX - 64'sd1;
    else                        wrap_sat = wrap_s;

    if (apply_load) begin
      acc_d = '0;
      sec_d = arm_sec_q;
    end else if (roll) begin
      acc_d = ACC_W'(wrap_sat);
      sec_d = sec_q + SEC_W'(1);
    end else begin
      acc_d = ACC_W'(sum_s);
      sec_d = sec_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      sec_q     <= '0;
      arm_sec_q <= '0;
      armed_q   <= 1'b0;
      trim_q    <= '0;
    end else begin
      acc_q   <= acc_d;
      sec_q   <= sec_d;
      armed_q <= armed_d;
      if (arm_we)  arm_sec_q <= cmd_sec;
      if (trim_we) trim_q    <= cmd_adj;
    end
  end

  assign armed_o  = armed_q;
  assign sec_o    = sec_q;
  assign subsec_o = SUB_W'(acc_q >> FRAC_W);
endmodule

// File: rtl/utc_timekeeper.sv
module utc_timekeeper
  import utc_pkg::*;
#(
  parameter int               FRC_W     = 64,
  parameter int               WORD_W    = 32,
  parameter logic [FRC_W-1:0] FRC_RST   = '0,
  parameter int unsigned      SEC_UNITS = 1000000000,
  parameter int               FRAC_W    = 8,
  parameter int unsigned      STEP_FX   = 1638,
  localparam int              SUB_W     = $clog2(SEC_UNITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pin_wr,
  input  logic [PIN_IDX_W-1:0] pin_idx,
  input  logic [MODE_W-1:0]    pin_mode,
  input  logic                 pin_en,
  input  logic [FRC_W-1:0]     pin_target,
  input  logic                 cmd_wr,
  input  logic [OP_W-1:0]      cmd_op,
  input  logic [TRIM_W-1:0]    cmd_adj,
  input  logic [SEC_W-1:0]     cmd_sec,
  input  logic                 rd_hi,
  output logic [WORD_W-1:0]    rd_word,
  output logic                 pps_pulse,
  output logic [SEC_W-1:0]     utc_sec,
  output logic [SUB_W-1:0]     utc_subsec
);
  logic             rst_sync_n;
  logic [FRC_W-1:0] frc_val;
  logic             fire;
  logic             armed;
  logic             apply_load;

  utc_rst_sync i_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  utc_frc #(.FRC_W(FRC_W), .WORD_W(WORD_W), .FRC_RST(FRC_RST)) i_frc (
    .clk(clk), .rst_n(rst_sync_n), .rd_hi(rd_hi),
    .frc_o(frc_val), .rd_word_o(rd_word)
  );

  utc_vpin #(.FRC_W(FRC_W)) i_vpin (
    .clk(clk), .rst_n(rst_sync_n), .pin_wr(pin_wr), .pin_idx(pin_idx),
    .pin_mode(pin_mode), .pin_en(pin_en), .pin_target(pin_target),
    .frc(frc_val), .fire_o(fire), .pps_o(pps_pulse)
  );

  assign apply_load = fire && armed;

  utc_tod #(.SEC_UNITS(SEC_UNITS), .FRAC_W(FRAC_W), .STEP_FX(STEP_FX),
            .SUB_W(SUB_W)) i_tod (
    .clk(clk), .rst_n(rst_sync_n), .cmd_wr(cmd_wr), .cmd_op(cmd_op),
    .cmd_adj(cmd_adj), .cmd_sec(cmd_sec), .apply_load(apply_load),
    .armed_o(armed), .sec_o(utc_sec), .subsec_o(utc_subsec)
  );
endmodule

// File: rtl/utc_timekeeper_chk.sv
module utc_timekeeper_chk #(
  parameter int          FRC_W     = 64,
  parameter int unsigned SEC_UNITS = 1000000000,
  parameter int          SUB_W     = 30
) (
  input logic             clk,
  input logic             rst_n,
  input logic [FRC_W-1:0] frc_val,
  input logic             pps_pulse,
  input logic             pin_wr,
  input logic             apply_load,
  input logic             cmd_wr,
  input logic [3:0]       cmd_op,
  input logic [31:0]      cmd_sec,
  input logic [31:0]      utc_sec,
  input logic [SUB_W-1:0] utc_subsec
);
  logic        live_q;
  logic [31:0] shadow_sec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q     <= 1'b0;
      shadow_sec <= '0;
    end else begin
      live_q <= 1'b1;
      if (cmd_wr && cmd_op == 4'd0) shadow_sec <= cmd_sec;
    end
  end

  // R1
  frc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> frc_val == $past(frc_val) + 1);

  // R4
  pps_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && pps_pulse && !$past(pin_wr)) |=> !pps_pulse);

  // R5
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(apply_load)) |-> (utc_sec == $past(shadow_sec) && utc_subsec == '0));

  // R8
  subsec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(utc_subsec) < SEC_UNITS);

  // R7
  sec_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !$past(apply_load)) |->
      (utc_sec == $past(utc_sec) || utc_sec == $past(utc_sec) + 32'd1));
endmodule

bind utc_timekeeper utc_timekeeper_chk #(
  .FRC_W(FRC_W), .SEC_UNITS(SEC_UNITS), .SUB_W(SUB_W)
) i_chk (
  .clk(clk), .rst_n(rst_sync_n), .frc_val(frc_val), .pps_pulse(pps_pulse),
  .pin_wr(pin_wr), .apply_load(apply_load), .cmd_wr(cmd_wr),
  .cmd_op(cmd_op), .cmd_sec(cmd_sec), .utc_sec(utc_sec),
  .utc_subsec(utc_subsec)
);

// File: tb/test_utc_timekeeper.sv
module test_utc_timekeeper;
  localparam logic [63:0] FRC_RST   = 64'h0000_0005_FFFF_FF00;
  localparam int          SEC_UNITS = 1000;
  localparam int          FRAC_W    = 8;
  localparam int          STEP_FX   = 1638;
  localparam int          SUB_W     = $clog2(SEC_UNITS);
  localparam longint      SEC_FX    = longint'(SEC_UNITS) * (1 << FRAC_W);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_wr = 1'b0;
  logic [7:0]  pin_idx = '0;
  logic [3:0]  pin_mode = '0;
  logic        pin_en = 1'b0;
  logic [63:0] pin_target = '0;
  logic        cmd_wr = 1'b0;
  logic [3:0]  cmd_op = '0;
  logic [31:0] cmd_adj = '0;
  logic [31:0] cmd_sec = '0;
  logic        rd_hi = 1'b0;
  logic [31:0] rd_word;
  logic        pps_pulse;
  logic [31:0] utc_sec;
  logic [SUB_W-1:0] utc_subsec;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  utc_timekeeper #(.FRC_RST(FRC_RST), .SEC_UNITS(SEC_UNITS), .FRAC_W(FRAC_W),
                   .STEP_FX(STEP_FX)) i_utc_timekeeper (
    .clk(clk), .rst_n(rst_n), .pin_wr(pin_wr), .pin_idx(pin_idx),
    .pin_mode(pin_mode), .pin_en(pin_en), .pin_target(pin_target),
    .cmd_wr(cmd_wr), .cmd_op(cmd_op), .cmd_adj(cmd_adj), .cmd_sec(cmd_sec),
    .rd_hi(rd_hi), .rd_word(rd_word), .pps_pulse(pps_pulse),
    .utc_sec(utc_sec), .utc_subsec(utc_subsec)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pin_write(input logic [7:0] idx, input logic [3:0] mode,
                           input logic en, input logic [63:0] tgt);
    pin_idx = idx; pin_mode = mode; pin_en = en; pin_target = tgt; pin_wr = 1'b1;
    @(negedge clk);
    pin_wr = 1'b0;
  endtask

  task automatic cmd_write(input logic [3:0] op, input logic [31:0] adj,
                           input logic [31:0] sec);
    cmd_op = op; cmd_adj = adj; cmd_sec = sec; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic get_frc(output logic [63:0] v);
    rd_hi = 1'b1; #0.5;
    v[63:32] = rd_word;
    rd_hi = 1'b0; #0.5;
    v[31:0] = rd_word;
  endtask

  task automatic wait_pps(output bit got);
    got = 1'b0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (pps_pulse) begin
        got = 1'b1;
        return;
      end
    end
  endtask

  // Remainder after the first rollover that follows a load (R7, R8)
  function automatic longint exp_sub(input longint trim);
    longint n, r;
    n = (SEC_FX + STEP_FX - 1) / STEP_FX;
    r = n * STEP_FX - SEC_FX + trim * (1 << FRAC_W);
    if (r < 0) r = 0;
    if (r >= SEC_FX) r = SEC_FX - 1;
    return r / (1 << FRAC_W);
  endfunction

  // Arm seconds, fire the pin, then watch the first rollover
  task automatic run_second(input longint trim, input int s);
    logic [63:0] now, seen;
    bit got;
    longint n;
    n = (SEC_FX + STEP_FX - 1) / STEP_FX;
    cmd_write(4'd0, 32'd0, 32'(s));
    get_frc(now);
    pin_write(8'd7, 4'h2, 1'b1, now + 64'd30);
    wait_pps(got);
    chk("R4 pulse seen", longint'(got), 1);
    get_frc(seen);
    chk("R4 counter at pulse", longint'(seen - now), 31);
    chk("R5 seconds loaded", longint'(utc_sec), longint'(s));
    chk("R5 subsec cleared", longint'(utc_subsec), 0);
    repeat (n - 1) tick();
    chk("R7 no early rollover", longint'(utc_sec), longint'(s));
    tick();
    chk("R7 rollover seconds", longint'(utc_sec), longint'(s) + 1);
    chk("R7/R8 remainder with trim", longint'(utc_subsec), exp_sub(trim));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] h1, l1, h2, l2, a, b;
    logic [63:0] now;
    bit found, got, any;
    longint trims [6];
    trims = '{0, 5, -3, 400, -2000, 2000};

    // R10 reset state
    repeat (3) tick();
    chk("R10 pulse in reset", longint'(pps_pulse), 0);
    chk("R10 sec in reset", longint'(utc_sec), 0);
    chk("R10 subsec in reset", longint'(utc_subsec), 0);
    rst_n = 1'b1;
    tick(); tick();
    chk("R1 counter reset value", longint'(rd_word), longint'(FRC_RST[31:0]));
    tick();
    chk("R1 first increment", longint'(rd_word), longint'(FRC_RST[31:0]) + 1);
    a = rd_word; tick(); b = rd_word;
    chk("R1 step of one", longint'(b - a), 1);
    rd_hi = 1'b1; #0.5;
    chk("R1 high word", longint'(rd_word), longint'(FRC_RST[63:32]));
    rd_hi = 1'b0;

    // R2 high/low/high across the low-word wrap
    found = 1'b0;
    for (int i = 0; i < 200 && !found; i++) begin
      tick(); rd_hi = 1'b1; #0.5; h1 = rd_word;
      tick(); rd_hi = 1'b0; #0.5; l1 = rd_word;
      tick(); rd_hi = 1'b1; #0.5; h2 = rd_word;
      if (h1 != h2) begin
        tick(); rd_hi = 1'b0; #0.5; l2 = rd_word;
        found = 1'b1;
        chk("R2 high advanced by one", longint'(h2), longint'(h1) + 1);
        chk("R2 reread low is post-wrap", longint'(l2 < 32'd8), 1);
      end
    end
    rd_hi = 1'b0;
    chk("R2 wrap observed", longint'(found), 1);

    // R3 rejected pin writes, R9 late target, R4 single pulse
    tick();
    any = 1'b0;
    pin_write(8'd6, 4'h2, 1'b1, 64'd0);
    repeat (4) begin tick(); any |= pps_pulse; end
    chk("R3 wrong index ignored", longint'(any), 0);
    pin_write(8'd7, 4'h1, 1'b1, 64'd0);
    repeat (4) begin tick(); any |= pps_pulse; end
    chk("R3 wrong mode ignored", longint'(any), 0);
    pin_write(8'd7, 4'h2, 1'b0, 64'd0);
    repeat (4) begin tick(); any |= pps_pulse; end
    chk("R3 disabled pin silent", longint'(any), 0);
    pin_write(8'd7, 4'h2, 1'b1, 64'd0);
    tick();
    chk("R9 past target fires next cycle", longint'(pps_pulse), 1);
    repeat (6) begin tick(); any |= pps_pulse; end
    chk("R4 no refire", longint'(any), 0);

    // R5, R7, R8 sweep over trims
    for (int k = 0; k < 6; k++) begin
      cmd_write(4'd3, 32'(trims[k]), 32'd0);
      run_second(trims[k], 100 + 10 * k);
    end

    // R6 ignored op codes do not change the trim
    cmd_write(4'd3, 32'd0, 32'd0);
    cmd_write(4'd5, 32'd400, 32'd0);
    cmd_write(4'd2, 32'd77, 32'd0);
    run_second(0, 300);

    // R5 arm consumed, R6 op 1 does not arm
    cmd_write(4'd1, 32'd0, 32'd77);
    get_frc(now);
    pin_write(8'd7, 4'h2, 1'b1, now + 64'd10);
    wait_pps(got);
    chk("R6/R5 pulse without arm", longint'(got), 1);
    chk("R5 no reload without arm", longint'(utc_sec), 301);
    chk("R5 subsec kept running", longint'(utc_subsec != '0), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule